// File: doc/BRIEF.md
# Outbound Write Bus-Master Sequencer

This block drains posted outbound writes onto a shared parallel bus. Each write is one entry in an address queue (base address, byte count, tag) with its payload waiting in a separate data queue. Once both are present, the sequencer requests the bus. On grant it presents the address for one cycle, then streams data beats until the target ends the transfer. Based on how the transfer ended, the write is resumed, dropped or retired.

Request/grant and target responses are modelled as plain signals rather than physical bus pins. The target reports how it ends each cycle on a 3-bit code. The meaning of that code depends on two inputs: one selects conventional or extended protocol mode, and the other selects memory or I/O writes.

A master latency timer is loaded from a programmable value at each address phase and counts down while the sequencer holds the bus. The queues are not stored here. The block tells them when to pop one beat, when to retire the address entry, and when to flush the whole write.

Top module: `ob_write_seq`

## Requirements
- R1: `bus_req` is high only when the sequencer is waiting for the bus and both `adq_valid` and `wdq_valid` are high. An address phase (`addr_valid`) begins only in the cycle after `bus_req` and `bus_gnt` were both high.
- R2: Code 6 (master abort) on `tgt_term` during the address phase raises `adq_flush` in that cycle. No data beat follows, and the sequencer returns to idle.
- R3: During a data phase, code 1 (retry) moves no beat. Code 2 (disconnect) moves the current beat if `tgt_ready` is high. Either code sends the sequencer back to request the bus. The next address phase presents the base address plus 4 bytes for every beat already moved.
- R4: The latency timer is loaded from `lat_load` in the address phase and decrements each data cycle until it reaches zero. The sequencer releases the bus and re-requests only when the timer is zero and `bus_gnt` is low. With `bus_gnt` high, expiry has no effect.
- R5: Code 4 (target abort) moves no beat and raises `adq_flush`. It also sets the sticky `tabort_err` bit, which stays set until reset.
- R6: When the last beat of the byte count moves, `adq_pop` pulses in that cycle and the sequencer goes idle. `adq_pop` and `adq_flush` are never high together.
- R7: Code 3 (single-data-phase disconnect) moves the current beat. With `xmode`=1 and `io_wr`=1 it retires the write like a normal completion. In every other mode and type combination it resumes like R3.
- R8: With `xmode`=1 and `io_wr`=1, code 5 (split response) accepts the current beat and parks the sequencer without a bus request. `adq_pop` pulses only when `split_done` is high with `split_tag` equal to the entry's tag. A completion carrying a different tag is ignored.
- R9: A data parity error (`perr` during a beat) does not stop the transfer: beats keep moving until the byte count is done. The error sets the sticky `perr_flag`.
- R10: With code 0 and `tgt_ready` low, the sequencer only inserts wait states. The beat stays offered, no pop occurs, and `addr_out` holds.
- R11: Code 0 with `tgt_ready` high moves one 4-byte beat. `wdq_pop` pulses in exactly the cycles in which a beat moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xmode | input | 1 | 1 = extended protocol mode, 0 = conventional |
| io_wr | input | 1 | 1 = I/O write, 0 = memory write |
| lat_load | input | LTW | Latency timer reload value |
| adq_valid | input | 1 | Address queue holds a completed entry |
| adq_addr | input | AW | Entry base address |
| adq_bytes | input | BCW | Entry byte count (non-zero multiple of 4) |
| adq_tag | input | TAGW | Entry tag used to match split completions |
| wdq_valid | input | 1 | Write data for the entry is present |
| adq_pop | output | 1 | Retire the address entry |
| adq_flush | output | 1 | Drop the address entry and its data |
| wdq_pop | output | 1 | One data beat consumed |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| addr_valid | output | 1 | Address phase in progress |
| addr_out | output | AW | Current transfer address |
| beat_valid | output | 1 | Data phase in progress, beat offered |
| tgt_ready | input | 1 | Target ready for the beat |
| tgt_term | input | 3 | Target termination code (0 none,1 retry,2 disconnect,3 single-phase disconnect,4 target abort,5 split,6 master abort) |
| perr | input | 1 | Data parity error on the current beat |
| split_done | input | 1 | Split completion message received |
| split_tag | input | TAGW | Tag of the split completion |
| tabort_err | output | 1 | Sticky target abort status |
| perr_flag | output | 1 | Sticky parity error status |

## Verification
The assertions assume that an address entry stays valid from the moment it is taken until the sequencer pops or flushes it. They also assume the data queue signals `wdq_valid` for as long as beats remain. The bench meets both by holding `adq_valid` and `wdq_valid` high across retries, grant loss and split waits, and dropping them only in the idle cycle after a pop or flush. The wait-state property applies only while grant is held. The bench removes grant only in the latency timer scenario, where it also keeps `tgt_ready` low.

// File: rtl/ob_write_seq.sv
module ob_write_seq #(
  parameter int AW         = 32,
  parameter int BCW        = 12,
  parameter int LTW        = 8,
  parameter int TAGW       = 4,
  parameter int BEAT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xmode,
  input  logic            io_wr,
  input  logic [LTW-1:0]  lat_load,
  input  logic            adq_valid,
  input  logic [AW-1:0]   adq_addr,
  input  logic [BCW-1:0]  adq_bytes,
  input  logic [TAGW-1:0] adq_tag,
  input  logic            wdq_valid,
  output logic            adq_pop,
  output logic            adq_flush,
  output logic            wdq_pop,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            addr_valid,
  output logic [AW-1:0]   addr_out,
  output logic            beat_valid,
  input  logic            tgt_ready,
  input  logic [2:0]      tgt_term,
  input  logic            perr,
  input  logic            split_done,
  input  logic [TAGW-1:0] split_tag,
  output logic            tabort_err,
  output logic            perr_flag
);
  localparam logic [BCW-1:0] BB_CNT  = BCW'(BEAT_BYTES);
  localparam logic [AW-1:0]  BB_ADDR = AW'(BEAT_BYTES);

  localparam logic [2:0] T_NONE  = 3'd0;
  localparam logic [2:0] T_RETRY = 3'd1;
  localparam logic [2:0] T_DISC  = 3'd2;
  localparam logic [2:0] T_SDP   = 3'd3;
  localparam logic [2:0] T_TABT  = 3'd4;
  localparam logic [2:0] T_SPLIT = 3'd5;
  localparam logic [2:0] T_MABT  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_SPLIT} st_t;

  st_t             state, nxt;
  logic [AW-1:0]   cur_addr;
  logic [BCW-1:0]  remain;
  logic [TAGW-1:0] cur_tag;
  logic [LTW-1:0]  lat_cnt;

  wire ext_io   = xmode & io_wr;
  wire in_data  = (state == S_DATA);
  wire t_abort  = in_data && tgt_term == T_TABT;
  wire t_split  = in_data && ext_io && tgt_term == T_SPLIT;
  wire beat_ok  = tgt_term == T_NONE || tgt_term == T_DISC ||
                  tgt_term == T_SDP  || (ext_io && tgt_term == T_SPLIT);
  wire beat_xfer = in_data && tgt_ready && beat_ok;
  wire last_beat = beat_xfer && remain == BB_CNT;
  wire sdp_done  = beat_xfer && ext_io && tgt_term == T_SDP;
  wire resume    = tgt_term == T_RETRY || tgt_term == T_DISC ||
                   tgt_term == T_SDP || tgt_term == T_SPLIT;
  wire lat_out   = lat_cnt == '0 && !bus_gnt;
  wire split_hit = state == S_SPLIT && split_done && split_tag == cur_tag;

  assign bus_req    = state == S_REQ && wdq_valid;
  assign addr_valid = state == S_ADDR;
  assign beat_valid = in_data;
  assign addr_out   = cur_addr;
  assign wdq_pop    = beat_xfer;
  assign adq_flush  = (addr_valid && tgt_term == T_MABT) || t_abort;
  assign adq_pop    = (in_data && !t_abort && !t_split && (last_beat || sdp_done)) || split_hit;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (adq_valid && wdq_valid) nxt = S_REQ;
      S_REQ:   if (bus_gnt && wdq_valid) nxt = S_ADDR;
      S_ADDR:  nxt = (tgt_term == T_MABT) ? S_IDLE : S_DATA;
      S_DATA: begin
        if (t_abort)                    nxt = S_IDLE;
        else if (t_split)               nxt = S_SPLIT;
        else if (last_beat || sdp_done) nxt = S_IDLE;
        else if (resume)                nxt = S_REQ;
        else if (lat_out)               nxt = S_REQ;
      end
      S_SPLIT: if (split_hit) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      cur_tag    <= '0;
      lat_cnt    <= '0;
      tabort_err <= 1'b0;
      perr_flag  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && adq_valid && wdq_valid) begin
        cur_addr <= adq_addr;
        remain   <= adq_bytes;
        cur_tag  <= adq_tag;
      end
      if (state == S_ADDR) lat_cnt <= lat_load;
      else if (in_data && lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
      if (beat_xfer) begin
        cur_addr <= cur_addr + BB_ADDR;
        remain   <= remain - BB_CNT;
      end
      if (t_abort) tabort_err <= 1'b1;
      if (in_data && perr) perr_flag <= 1'b1;
    end
  end
endmodule

module ob_write_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adq_valid,
  input logic          wdq_valid,
  input logic          adq_pop,
  input logic          adq_flush,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          addr_valid,
  input logic [AW-1:0] addr_out,
  input logic          beat_valid,
  input logic          tgt_ready,
  input logic [2:0]    tgt_term,
  input logic          perr,
  input logic          tabort_err,
  input logic          perr_flag
);
  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> adq_valid && wdq_valid); // R1
  AST_ADDR_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> $past(bus_req && bus_gnt)); // R1
  AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    adq_flush |=> !beat_valid && !addr_valid); // R2
  AST_TABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tabort_err |=> tabort_err); // R5
  AST_POP_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(adq_pop && adq_flush)); // R6
  AST_PERR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && perr |=> perr_flag); // R9
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !tgt_ready && tgt_term == 3'd0 && bus_gnt |=> beat_valid && $stable(addr_out)); // R10
endmodule

bind ob_write_seq ob_write_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adq_valid(adq_valid), .wdq_valid(wdq_valid),
  .adq_pop(adq_pop), .adq_flush(adq_flush), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .addr_valid(addr_valid), .addr_out(addr_out), .beat_valid(beat_valid),
  .tgt_ready(tgt_ready), .tgt_term(tgt_term), .perr(perr),
  .tabort_err(tabort_err), .perr_flag(perr_flag)
);

// File: tb/sim_ob_write_seq.sv
module sim_ob_write_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xmode = 1'b0, io_wr = 1'b0;
  logic [7:0]  lat_load = '0;
  logic        adq_valid = 1'b0;
  logic [31:0] adq_addr = '0;
  logic [11:0] adq_bytes = '0;
  logic [3:0]  adq_tag = '0;
  logic        wdq_valid = 1'b0;
  logic        adq_pop, adq_flush, wdq_pop, bus_req, addr_valid, beat_valid;
  logic [31:0] addr_out;
  logic        bus_gnt = 1'b0, tgt_ready = 1'b0, perr = 1'b0, split_done = 1'b0;
  logic [2:0]  tgt_term = '0;
  logic [3:0]  split_tag = '0;
  logic        tabort_err, perr_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ob_write_seq u0 (
    .clk(clk), .rst_n(rst_n), .xmode(xmode), .io_wr(io_wr), .lat_load(lat_load),
    .adq_valid(adq_valid), .adq_addr(adq_addr), .adq_bytes(adq_bytes), .adq_tag(adq_tag),
    .wdq_valid(wdq_valid), .adq_pop(adq_pop), .adq_flush(adq_flush), .wdq_pop(wdq_pop),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .addr_valid(addr_valid), .addr_out(addr_out),
    .beat_valid(beat_valid), .tgt_ready(tgt_ready), .tgt_term(tgt_term), .perr(perr),
    .split_done(split_done), .split_tag(split_tag), .tabort_err(tabort_err),
    .perr_flag(perr_flag)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] a, input logic [11:0] n, input logic [3:0] tg);
    adq_addr = a; adq_bytes = n; adq_tag = tg;
    adq_valid = 1'b1; wdq_valid = 1'b1; bus_gnt = 1'b1;
    step;
  endtask

  task automatic addr_ph(input logic [31:0] a, input logic [2:0] t, input logic ef, input string r);
    chk({r, " bus_req"}, 32'(bus_req), 32'd1);
    step;
    chk({r, " addr_valid"}, 32'(addr_valid), 32'd1);
    chk({r, " addr_out"}, addr_out, a);
    tgt_term = t;
    #1 chk({r, " adq_flush"}, 32'(adq_flush), 32'(ef));
    step;
    tgt_term = 3'd0;
  endtask

  task automatic beat(input logic [2:0] t, input logic ewp, input logic eap, input string r);
    tgt_ready = 1'b1; tgt_term = t;
    #1;
    chk({r, " wdq_pop"}, 32'(wdq_pop), 32'(ewp));
    chk({r, " adq_pop"}, 32'(adq_pop), 32'(eap));
    step;
    tgt_ready = 1'b0; tgt_term = 3'd0;
  endtask

  task automatic finish_entry(input string r);
    adq_valid = 1'b0; wdq_valid = 1'b0;
    step;
    chk({r, " idle req"}, 32'(bus_req), 32'd0);
    chk({r, " idle beat"}, 32'(beat_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset bus_req", 32'(bus_req), 32'd0);
    chk("R1 reset addr_valid", 32'(addr_valid), 32'd0);
    chk("R5 reset tabort_err", 32'(tabort_err), 32'd0);
    chk("R9 reset perr_flag", 32'(perr_flag), 32'd0);
  endtask

  task automatic t_no_data;
    adq_valid = 1'b1; wdq_valid = 1'b0; bus_gnt = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step;
      chk("R1 no data no req", 32'(bus_req), 32'd0);
      chk("R1 no data no addr", 32'(addr_valid), 32'd0);
    end
    adq_valid = 1'b0;
    step;
  endtask

  task automatic t_normal;
    arm(32'h1000, 12'd12, 4'd1);
    addr_ph(32'h1000, 3'd0, 1'b0, "R6");
    for (int i = 0; i < 2; i++) begin
      tgt_ready = 1'b0;
      #1;
      chk("R10 wait beat held", 32'(beat_valid), 32'd1);
      chk("R10 wait no pop", 32'(wdq_pop), 32'd0);
      chk("R10 wait addr", addr_out, 32'h1000);
      step;
    end
    beat(3'd0, 1'b1, 1'b0, "R11 beat1");
    beat(3'd0, 1'b1, 1'b0, "R11 beat2");
    beat(3'd0, 1'b1, 1'b1, "R6 last beat");
    finish_entry("R6");
  endtask

  task automatic t_mabort;
    arm(32'h1800, 12'd8, 4'd2);
    addr_ph(32'h1800, 3'd6, 1'b1, "R2 master abort");
    chk("R2 no beat", 32'(beat_valid), 32'd0);
    finish_entry("R2");
  endtask

  task automatic t_retry;
    arm(32'h2000, 12'd16, 4'd2);
    addr_ph(32'h2000, 3'd0, 1'b0, "R3");
    beat(3'd0, 1'b1, 1'b0, "R3 beat");
    beat(3'd1, 1'b0, 1'b0, "R3 retry");
    chk("R3 retry rereq", 32'(bus_req), 32'd1);
    chk("R3 retry no beat", 32'(beat_valid), 32'd0);
    addr_ph(32'h2004, 3'd0, 1'b0, "R3 resume1");
    beat(3'd2, 1'b1, 1'b0, "R3 disconnect");
    addr_ph(32'h2008, 3'd0, 1'b0, "R3 resume2");
    beat(3'd0, 1'b1, 1'b0, "R3 beat3");
    beat(3'd0, 1'b1, 1'b1, "R3 last");
    finish_entry("R3");
  endtask

  task automatic t_latency;
    lat_load = 8'd2;
    arm(32'h3000, 12'd8, 4'd3);
    addr_ph(32'h3000, 3'd0, 1'b0, "R4");
    bus_gnt = 1'b0;
    chk("R4 timer c1", 32'(beat_valid), 32'd1);
    step;
    chk("R4 timer c2", 32'(beat_valid), 32'd1);
    step;
    chk("R4 timer c3", 32'(beat_valid), 32'd1);
    step;
    chk("R4 released", 32'(beat_valid), 32'd0);
    chk("R4 rereq", 32'(bus_req), 32'd1);
    bus_gnt = 1'b1;
    addr_ph(32'h3000, 3'd0, 1'b0, "R4 resume");
    beat(3'd0, 1'b1, 1'b0, "R4 beat");
    beat(3'd0, 1'b1, 1'b1, "R4 last");
    finish_entry("R4");
    lat_load = 8'd0;
  endtask

  task automatic t_tabort;
    arm(32'h4000, 12'd8, 4'd4);
    addr_ph(32'h4000, 3'd0, 1'b0, "R5");
    beat(3'd0, 1'b1, 1'b0, "R5 beat");
    tgt_ready = 1'b1; tgt_term = 3'd4;
    #1;
    chk("R5 abort no beat", 32'(wdq_pop), 32'd0);
    chk("R5 abort flush", 32'(adq_flush), 32'd1);
    chk("R5 abort no pop", 32'(adq_pop), 32'd0);
    step;
    tgt_ready = 1'b0; tgt_term = 3'd0;
    chk("R5 err set", 32'(tabort_err), 32'd1);
    finish_entry("R5");
    chk("R5 err sticky", 32'(tabort_err), 32'd1);
  endtask

  task automatic t_sdp;
    xmode = 1'b1; io_wr = 1'b0;
    arm(32'h5000, 12'd8, 4'd5);
    addr_ph(32'h5000, 3'd0, 1'b0, "R7 mem");
    beat(3'd3, 1'b1, 1'b0, "R7 mem sdp");
    addr_ph(32'h5004, 3'd0, 1'b0, "R7 mem resume");
    beat(3'd0, 1'b1, 1'b1, "R7 mem last");
    finish_entry("R7 mem");
    io_wr = 1'b1;
    arm(32'h5100, 12'd8, 4'd6);
    addr_ph(32'h5100, 3'd0, 1'b0, "R7 io");
    beat(3'd3, 1'b1, 1'b1, "R7 io sdp completes");
    finish_entry("R7 io");
    xmode = 1'b0; io_wr = 1'b0;
  endtask

  task automatic t_split;
    xmode = 1'b1; io_wr = 1'b1;
    arm(32'h6000, 12'd4, 4'd9);
    addr_ph(32'h6000, 3'd0, 1'b0, "R8");
    beat(3'd5, 1'b1, 1'b0, "R8 split");
    chk("R8 parked no req", 32'(bus_req), 32'd0);
    chk("R8 parked no beat", 32'(beat_valid), 32'd0);
    split_done = 1'b1; split_tag = 4'd3;
    #1 chk("R8 wrong tag ignored", 32'(adq_pop), 32'd0);
    step;
    split_tag = 4'd9;
    #1 chk("R8 matching tag pops", 32'(adq_pop), 32'd1);
    step;
    split_done = 1'b0;
    finish_entry("R8");
    xmode = 1'b0; io_wr = 1'b0;
  endtask

  task automatic t_parity;
    arm(32'h7000, 12'd8, 4'd7);
    addr_ph(32'h7000, 3'd0, 1'b0, "R9");
    perr = 1'b1;
    beat(3'd0, 1'b1, 1'b0, "R9 beat with perr");
    perr = 1'b0;
    chk("R9 flag", 32'(perr_flag), 32'd1);
    chk("R9 continues", 32'(beat_valid), 32'd1);
    beat(3'd0, 1'b1, 1'b1, "R9 drained");
    finish_entry("R9");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_data;
    t_normal;
    t_mabort;
    t_retry;
    t_latency;
    t_tabort;
    t_sdp;
    t_split;
    t_parity;
    summary;
  end
endmodule